// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave model of a byte-wide serial EEPROM that answers on a two-wire bus. It has 4096 bytes of storage in an internal register array. The block does not run on the serial clock. It samples SCL and SDA with its own system clock through a short synchronizer, and it drives the data line open-drain style: a single enable output pulls SDA low when it is high.

Three strap inputs set the low bits of the device address, so eight devices can share one bus. The block supports single-byte and page writes, which latch up to one 32-byte page and commit it after the stop. It also supports reads at the current internal address, random reads that follow a dummy write, and sequential reads that continue as long as the master acknowledges. A write-protect input makes the block accept write data without storing it. After a stop that ends a write with data, a busy window of a set number of system clocks begins, and the block ignores its own address until the window ends.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The device select byte is the fixed type 4'b1010 in bits 7:4, the strap value in bits 3:1 and the read flag (1 = read) in bit 0. A byte that does not match gets no acknowledge, and the block keeps SDA released for every later byte until the next start.
- R2: For each byte the block accepts (device select, either address byte, write data), it pulls SDA low for the whole ninth SCL clock.
- R3: The word address follows the write device select as two bytes, high byte first. Only the low 4 bits of the high byte are used, so a high byte of 8'hF1 and one of 8'h01 select the same location.
- R4: A byte written as device select, two address bytes, one data byte and stop is read back unchanged once the busy window has ended.
- R5: In a page write the low 5 address bits advance after each data byte and wrap inside the 32-byte page, so the upper 7 address bits never change. A 33rd byte replaces the first one. Locations outside the page are left unchanged.
- R6: A read device select with no address phase returns the byte at the internal address. That address is one past the last byte read or written.
- R7: A random read (write select, two address bytes, repeated start, read select) returns the byte at the given address.
- R8: A read continues byte by byte while the master acknowledges, going from location 4095 to location 0, and ends when the master does not acknowledge.
- R9: While the write-protect input is high, data bytes are still acknowledged but nothing is stored, and no busy window starts.
- R10: For WR_CYCLES system clocks after a stop that ends a write with at least one unprotected data byte, the device select byte gets no acknowledge. After that window it is acknowledged again.
- R11: A falling SDA while SCL is high (start) and a rising SDA while SCL is high (stop) are always recognised. Write data followed by a repeated start instead of a stop is discarded. The enable output changes only while SCL is low.
- R12: After reset, SDA is released and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (the wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel_i | input | 3 | Strap value for device address bits 3:1 |
| wp_i | input | 1 | 1 blocks all storage updates |

## Verification
The acknowledge or read bit appears about three system clocks after SCL falls: two clocks for the synchronizer and one for the output register. The bench master keeps SCL low for two quarter periods of 8 clocks and samples SDA in the middle of the high phase, well after that latency. Written data reaches the array during the first 32 clocks of the busy window. The bench therefore checks stored data only after it has waited the whole window of WR_CYCLES plus margin. It probes busy behaviour by addressing the device straight after the stop, which is about 330 clocks into a 1500-clock window. Ignored-data cases are checked by reading the untouched locations back through the normal read sequence.

// File: rtl/tw_eeprom_pkg.sv
// Shared types and constants for the two-wire EEPROM slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tw_eeprom_pkg;

    // Fixed device type code in bits 7:4 of the device select byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Bit counter values within one byte frame
    localparam logic [3:0] BIT_ACK  = 4'd8;
    localparam logic [3:0] BIT_DONE = 4'd9;

    // Protocol controller states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEV  = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_WDAT = 3'd4,
        ST_RD   = 3'd5
    } tw_state_e;

endpackage

// File: rtl/tw_bus_sync.sv
// Bus sampler: brings SCL and SDA into the system clock domain and
// flags rising and falling SCL edges and start and stop conditions.
// Assumes the system clock is several times faster than SCL.
module tw_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_s, scl_p, sda_s, sda_p;

    // Shift both lines through the synchronizer; idle bus reads high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign scl_p = scl_pipe[SYNC_STAGES];
    assign sda_s = sda_pipe[SYNC_STAGES-1];
    assign sda_p = sda_pipe[SYNC_STAGES];

    // Edge and condition decode on the synchronized levels
    always_comb begin
        scl_lvl   = scl_s;
        sda_lvl   = sda_s;
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/tw_page_buf.sv
// Page buffer: holds up to one page of write data plus a per-byte
// valid mask until the commit sequencer moves it into the array.
// Assumes clr and we are never asserted in the same cycle.
module tw_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int PG_W = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            we,
    input  logic [PG_W-1:0] widx,
    input  logic [7:0]      wdata,
    input  logic [PG_W-1:0] ridx,
    output logic [7:0]      rdata,
    output logic            rvalid,
    output logic            any_valid
);

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    // One data register per page slot
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Capture the byte addressed to this slot
        always_ff @(posedge clk) begin
            if (we && widx == PG_W'(g)) begin
                slot[g] <= wdata;
            end
        end
    end

    // Track which slots hold data of the current sequence
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[widx] <= 1'b1;
        end
    end

    assign rdata     = slot[ridx];
    assign rvalid    = valid_q[ridx];
    assign any_valid = |valid_q;

endmodule

// File: rtl/tw_write_timer.sv
// Write cycle timer: after a start pulse it stays busy for WR_CYCLES
// clocks and, in the first PAGE_BYTES of them, steps a slot index
// used to commit the page buffer into the array one byte per clock.
// Assumes WR_CYCLES >= PAGE_BYTES.
module tw_write_timer #(
    parameter int WR_CYCLES  = 2000,
    parameter int PAGE_BYTES = 32,
    localparam int PG_W = $clog2(PAGE_BYTES),
    localparam int TM_W = $clog2(WR_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            commit_en,
    output logic [PG_W-1:0] commit_idx
);

    localparam logic [TM_W-1:0] LAST   = TM_W'(WR_CYCLES - 1);
    localparam logic [TM_W-1:0] PG_LIM = TM_W'(PAGE_BYTES);

    logic [TM_W-1:0] tick_q;
    logic            run_q;

    // Run the busy window from start until its last clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            tick_q <= '0;
        end else if (start && !run_q) begin
            run_q  <= 1'b1;
            tick_q <= '0;
        end else if (run_q) begin
            if (tick_q == LAST) begin
                run_q <= 1'b0;
            end
            tick_q <= tick_q + 1'b1;
        end
    end

    assign busy       = run_q;
    assign commit_en  = run_q && (tick_q < PG_LIM);
    assign commit_idx = tick_q[PG_W-1:0];

    initial begin
        AST_WINDOW_FITS_PAGE: assert (WR_CYCLES >= PAGE_BYTES); // R10
    end

endmodule

// File: rtl/tw_store.sv
// Storage array: one synchronous write port used by the commit
// sequencer and one asynchronous read port at the internal address.
// Contents are not reset.
module tw_store #(
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    // Commit one byte per clock when enabled
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tw_proto_ctrl.sv
// Protocol controller: decodes device select, word address and data
// bytes, drives acknowledge and read data on SDA, keeps the internal
// address and feeds write data to the page buffer.
// Assumes edge and condition pulses come from the bus sampler and that
// start/stop never coincide with an SCL edge pulse.
module tw_proto_ctrl
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    localparam int PG_W = $clog2(PAGE_BYTES),
    localparam int HI_W = ADDR_W - 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_lvl,
    input  logic                   sda_lvl,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_det,
    input  logic                   stop_det,
    input  logic [2:0]             dev_sel,
    input  logic                   wp,
    input  logic                   busy,
    input  logic                   buf_any,
    input  logic [7:0]             rd_data,
    output logic                   sda_oe,
    output logic [ADDR_W-1:0]      cur_addr,
    output logic [ADDR_W-PG_W-1:0] pg_base,
    output logic                   buf_we,
    output logic [PG_W-1:0]        buf_idx,
    output logic [7:0]             buf_data,
    output logic                   buf_clr,
    output logic                   commit_go
);

    tw_state_e        st_q, nxt_q;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic             oe_q;
    logic             mack_q;
    logic [HI_W-1:0]  hi_q;
    logic             rx_state;
    logic             byte_end;
    logic             dev_ok;

    // Decode helpers shared by the sequential logic and the outputs
    always_comb begin
        rx_state  = (st_q == ST_DEV) || (st_q == ST_AHI) ||
                    (st_q == ST_ALO) || (st_q == ST_WDAT);
        byte_end  = scl_fall && (bit_cnt == BIT_ACK);
        dev_ok    = (rx_sh[7:1] == {DEV_TYPE, dev_sel}) && !busy;
        buf_we    = (st_q == ST_WDAT) && byte_end && !wp;
        buf_idx   = cur_addr[PG_W-1:0];
        buf_data  = rx_sh;
        buf_clr   = (st_q == ST_ALO) && byte_end;
        commit_go = stop_det && (st_q == ST_WDAT) && buf_any;
    end

    // Main byte-level sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            nxt_q    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            oe_q     <= 1'b0;
            mack_q   <= 1'b0;
            hi_q     <= '0;
            cur_addr <= '0;
            pg_base  <= '0;
        end else if (start_det) begin
            st_q    <= ST_DEV;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (stop_det) begin
            st_q    <= ST_IDLE;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (rx_state) begin
            if (scl_rise) begin
                if (bit_cnt < BIT_ACK) begin
                    rx_sh   <= {rx_sh[6:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (bit_cnt == BIT_ACK) begin
                    bit_cnt <= BIT_DONE;
                end
            end else if (byte_end) begin
                oe_q <= 1'b1;
                unique case (st_q)
                    ST_DEV: begin
                        if (dev_ok) begin
                            nxt_q <= rx_sh[0] ? ST_RD : ST_AHI;
                        end else begin
                            oe_q <= 1'b0;
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        hi_q  <= rx_sh[HI_W-1:0];
                        nxt_q <= ST_ALO;
                    end
                    ST_ALO: begin
                        cur_addr <= {hi_q, rx_sh};
                        pg_base  <= {hi_q, rx_sh[7:PG_W]};
                        nxt_q    <= ST_WDAT;
                    end
                    default: begin
                        cur_addr[PG_W-1:0] <= cur_addr[PG_W-1:0] + 1'b1;
                        nxt_q              <= ST_WDAT;
                    end
                endcase
            end else if (scl_fall && bit_cnt == BIT_DONE) begin
                bit_cnt <= '0;
                st_q    <= nxt_q;
                if (nxt_q == ST_RD) begin
                    tx_sh <= rd_data;
                    oe_q  <= ~rd_data[7];
                end else begin
                    oe_q <= 1'b0;
                end
            end
        end else if (st_q == ST_RD) begin
            if (scl_rise) begin
                if (bit_cnt < BIT_ACK) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (bit_cnt == BIT_ACK) begin
                    bit_cnt <= BIT_DONE;
                    mack_q  <= ~sda_lvl;
                end
            end else if (scl_fall) begin
                if (bit_cnt == BIT_ACK) begin
                    oe_q     <= 1'b0;
                    cur_addr <= cur_addr + 1'b1;
                end else if (bit_cnt == BIT_DONE) begin
                    if (mack_q) begin
                        tx_sh   <= rd_data;
                        oe_q    <= ~rd_data[7];
                        bit_cnt <= '0;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end else if (bit_cnt != '0) begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    oe_q  <= ~tx_sh[6];
                end
            end
        end
    end

    assign sda_oe = oe_q;

    // Outside a read, SDA is only pulled in the acknowledge slot
    AST_ACK_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && st_q != ST_RD) |-> (bit_cnt >= BIT_ACK)); // R2

    // The enable output never moves while SCL is high
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q != $past(oe_q)) |-> !scl_lvl); // R11

    // A device select arriving during the write cycle is not acknowledged
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEV && byte_end && busy) |=> !oe_q); // R10

    // Page writes never leave the current page
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WDAT) |=>
        (cur_addr[ADDR_W-1:PG_W] == $past(cur_addr[ADDR_W-1:PG_W]))); // R5

    // Reset leaves the line released
    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> !oe_q); // R12

endmodule

// File: rtl/tw_eeprom_slave.sv
// Two-wire serial EEPROM slave top: bus sampler, protocol controller,
// page buffer, write cycle timer and storage array.
// Assumes sda_i carries the wired bus level, including its own pull.
module tw_eeprom_slave #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_BYTES  = 32,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_i
);

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int PB_W = ADDR_W - PG_W;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, commit_en, commit_go;
    logic [PG_W-1:0]   commit_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic [PB_W-1:0]   pg_base;
    logic              buf_we, buf_clr, buf_any, buf_rvalid;
    logic [PG_W-1:0]   buf_idx;
    logic [7:0]        buf_wdata, buf_rdata, rd_data;
    logic              arr_we;

    tw_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_proto_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_sel   (dev_sel_i),
        .wp        (wp_i),
        .busy      (busy),
        .buf_any   (buf_any),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .cur_addr  (cur_addr),
        .pg_base   (pg_base),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .buf_data  (buf_wdata),
        .buf_clr   (buf_clr),
        .commit_go (commit_go)
    );

    tw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) i_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .we        (buf_we),
        .widx      (buf_idx),
        .wdata     (buf_wdata),
        .ridx      (commit_idx),
        .rdata     (buf_rdata),
        .rvalid    (buf_rvalid),
        .any_valid (buf_any)
    );

    tw_write_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (commit_go),
        .busy       (busy),
        .commit_en  (commit_en),
        .commit_idx (commit_idx)
    );

    // Only slots filled in the current sequence reach the array
    assign arr_we = commit_en && buf_rvalid;

    tw_store #(.ADDR_W(ADDR_W)) i_store (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({pg_base, commit_idx}),
        .wdata (buf_rdata),
        .raddr (cur_addr),
        .rdata (rd_data)
    );

    // Array updates happen only inside the busy window
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R10

    // No new write sequence can open while a commit is running
    AST_NO_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_clr || commit_go) |-> !busy); // R10

    // Reset leaves the write cycle idle
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !busy); // R12

endmodule

// File: tb/test_tw_eeprom_slave.sv
// Self-checking bench: bit-level bus master, a vector table of byte
// writes and random reads, then directed protocol corner cases.
module test_tw_eeprom_slave;

    localparam int CLK_PER  = 10;
    localparam int Q        = 8;
    localparam int WR_CYC   = 1500;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int NVEC     = 6;
    // {raw 16-bit word address, data}
    localparam logic [23:0] VEC [NVEC] = '{
        24'hF1235A, 24'h0124C3, 24'h0FFF77,
        24'h000011, 24'h04209E, 24'h00012B
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PER/2) clk = ~clk;

    tw_eeprom_slave #(.WR_CYCLES(WR_CYC)) i_tw_eeprom_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .dev_sel_i (STRAP),
        .wp_i      (wp)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic m_start;
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;
    endtask

    task automatic m_stop;
        wq(Q); sda_m = 1'b0;
        wq(Q); scl = 1'b1;
        wq(Q); sda_m = 1'b1;
        wq(Q);
    endtask

    task automatic m_wr(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = b[i];
            wq(Q); scl = 1'b1;
            wq(2*Q); scl = 1'b0;
        end
        wq(Q); sda_m = 1'b1;
        wq(Q); scl = 1'b1;
        wq(Q); ack = ~sda_line;
        wq(Q); scl = 1'b0;
    endtask

    task automatic m_rd(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(2*Q); scl = 1'b1;
            wq(Q); b[i] = sda_line;
            wq(Q); scl = 1'b0;
        end
        wq(Q); sda_m = mack ? 1'b0 : 1'b1;
        wq(Q); scl = 1'b1;
        wq(2*Q); scl = 1'b0;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dsel(input bit rd);
        return {4'b1010, STRAP, rd};
    endfunction

    // Start, write select and two address bytes; returns AND of acks
    task automatic m_addr(input logic [15:0] a, output bit ok);
        bit k;
        ok = 1'b1;
        m_start;
        m_wr(dsel(1'b0), k); ok &= k;
        m_wr(a[15:8], k);    ok &= k;
        m_wr(a[7:0], k);     ok &= k;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, output bit ok);
        bit k;
        m_addr(a, ok);
        m_wr(d, k); ok &= k;
        m_stop;
    endtask

    // Random read of n bytes (master acks all but the last)
    task automatic do_rread(input logic [15:0] a, input int n, output logic [7:0] d [4], output bit ok);
        bit k;
        m_addr(a, ok);
        m_start;
        m_wr(dsel(1'b1), k); ok &= k;
        for (int i = 0; i < n; i++) begin
            m_rd(i != n - 1, d[i]);
        end
        m_stop;
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        wq(190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            report;
        end
    end

    initial begin
        logic [7:0] rb [4];
        logic [7:0] b;
        bit ok, k;

        wq(5);
        // R12: line released in reset and after release
        chk(sda_oe == 1'b0, "R12 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wq(5);
        chk(sda_oe == 1'b0, "R12 oe after reset", sda_oe, 0);

        // Vector table: byte write, wait out the window, random read back
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][23:8], VEC[v][7:0], ok);
            chk(ok, "R2 write acks", ok, 1);
            wq(WR_CYC + 50);
            do_rread(VEC[v][23:8], 1, rb, ok);
            chk(ok, "R7 read acks", ok, 1);
            chk(rb[0] == VEC[v][7:0], "R4 R7 readback", rb[0], VEC[v][7:0]);
        end

        // R3: upper nibble of high address byte ignored
        do_rread(16'h0123, 1, rb, ok);
        chk(rb[0] == 8'h5A, "R3 upper nibble ignored", rb[0], 8'h5A);

        // R6: current address read continues after 0x123 -> 0x124
        m_start;
        m_wr(dsel(1'b1), k);
        chk(k, "R6 select ack", k, 1);
        m_rd(1'b0, b);
        m_stop;
        chk(b == 8'hC3, "R6 current address", b, 8'hC3);

        // R1: wrong strap value is ignored, bus stays released
        m_start;
        m_wr({4'b1010, 3'b011, 1'b0}, k);
        chk(!k, "R1 mismatch nack", k, 0);
        m_wr(8'h00, k);
        chk(!k, "R1 idle until start", k, 0);
        m_stop;
        // R1: wrong type code is ignored
        m_start;
        m_wr({4'b1011, STRAP, 1'b0}, k);
        chk(!k, "R1 type mismatch nack", k, 0);
        m_stop;

        // R10: device select rejected inside busy window, accepted after
        do_write(16'h0002, 8'h66, ok);
        m_start;
        m_wr(dsel(1'b0), k);
        chk(!k, "R10 busy nack", k, 0);
        m_stop;
        wq(WR_CYC + 50);
        m_start;
        m_wr(dsel(1'b0), k);
        chk(k, "R10 ack after window", k, 1);
        m_stop;
        do_rread(16'h0002, 1, rb, ok);
        chk(rb[0] == 8'h66, "R10 data after window", rb[0], 8'h66);

        // R8: sequential read wraps 0xFFF -> 0x000 -> 0x001
        do_rread(16'h0FFF, 3, rb, ok);
        chk(rb[0] == 8'h77, "R8 seq byte0", rb[0], 8'h77);
        chk(rb[1] == 8'h11, "R8 seq wrap", rb[1], 8'h11);
        chk(rb[2] == 8'h2B, "R8 seq byte2", rb[2], 8'h2B);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        m_start;
        m_wr(dsel(1'b1), k);
        m_rd(1'b0, b);
        m_stop;
        chk(b == 8'h66, "R6 R8 address after seq", b, 8'h66);

        // R9: protected write acked, nothing stored, no busy window
        wp = 1'b1;
        do_write(16'h0123, 8'hEE, ok);
        chk(ok, "R9 protected acks", ok, 1);
        m_start;
        m_wr(dsel(1'b0), k);
        chk(k, "R9 no busy", k, 1);
        m_stop;
        wp = 1'b0;
        wq(WR_CYC + 50);
        do_rread(16'h0123, 1, rb, ok);
        chk(rb[0] == 8'h5A, "R9 array unchanged", rb[0], 8'h5A);

        // R11: data then repeated start is discarded
        m_addr(16'h0124, ok);
        m_wr(8'hFF, k);
        m_start;
        m_wr(dsel(1'b1), k);
        chk(k, "R11 repeated start select", k, 1);
        m_rd(1'b0, b);
        m_stop;
        m_start;
        m_wr(dsel(1'b0), k);
        chk(k, "R11 no busy after abort", k, 1);
        m_stop;
        do_rread(16'h0124, 1, rb, ok);
        chk(rb[0] == 8'hC3, "R11 aborted data dropped", rb[0], 8'hC3);

        // R5: page write wraps 0x41E,0x41F,0x400,0x401
        m_addr(16'h041E, ok);
        for (int i = 0; i < 4; i++) begin
            m_wr(8'hD0 + 8'(i), k);
            chk(k, "R5 R2 page data ack", k, 1);
        end
        m_stop;
        wq(WR_CYC + 50);
        do_rread(16'h041E, 2, rb, ok);
        chk(rb[0] == 8'hD0, "R5 page 41E", rb[0], 8'hD0);
        chk(rb[1] == 8'hD1, "R5 page 41F", rb[1], 8'hD1);
        do_rread(16'h0400, 2, rb, ok);
        chk(rb[0] == 8'hD2, "R5 page wrap 400", rb[0], 8'hD2);
        chk(rb[1] == 8'hD3, "R5 page wrap 401", rb[1], 8'hD3);
        do_rread(16'h0420, 1, rb, ok);
        chk(rb[0] == 8'h9E, "R5 next page untouched", rb[0], 8'h9E);

        // R5: 33 bytes into page 0x7E0, last one replaces the first
        m_addr(16'h07E0, ok);
        for (int i = 0; i < 33; i++) begin
            m_wr(8'h40 + 8'(i), k);
        end
        m_stop;
        wq(WR_CYC + 50);
        do_rread(16'h07E0, 2, rb, ok);
        chk(rb[0] == 8'h60, "R5 overwrite first", rb[0], 8'h60);
        chk(rb[1] == 8'h41, "R5 second kept", rb[1], 8'h41);
        do_rread(16'h07FF, 1, rb, ok);
        chk(rb[0] == 8'h5F, "R5 last slot", rb[0], 8'h5F);

        done = 1'b1;
        report;
    end

endmodule